// File: doc/BRIEF.md
# Single-Cycle Integer Core

The block is a 32-bit processor that completes one instruction per clock. In each cycle it reads the word the program counter points to and decodes its opcode and function fields into a set of steering controls. It reads two source registers and runs the ALU. Then it either writes a result into the register file, stores a word into data memory, or redirects the program counter. The instruction set is deliberately small: register add, subtract, AND, OR and signed set-less-than; OR with an immediate; word load and store; branch on equal; and an absolute jump.

Instruction and data storage are word arrays inside the core. A test environment preloads them by hierarchical assignment before reset is released. The core makes its retirement effects visible on ports:
- the current program counter;
- the register write it is making in this cycle (enable, index, value);
- the memory store it is making in this cycle (enable, address, value).

All these outputs are combinational from the current instruction. They belong to the instruction that the program counter holds now.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset holds the program counter at 0. The first instruction after reset is the word at byte address 0.
- R2: R-format instructions (opcode 0x00) with funct 0x20 add, 0x22 subtract, 0x24 AND and 0x25 OR write R[rs] op R[rt] into register rd. Fields: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0].
- R3: funct 0x2A writes 1 into rd when R[rs] is less than R[rt] as signed 32-bit values, and writes 0 otherwise, including when the two are equal.
- R4: Opcode 0x0D writes R[rs] OR the zero-extended imm16 (bits [15:0]) into register rt.
- R5: Opcode 0x23 writes into rt the data word at word index (R[rs] + sign-extended imm16)[7:2]. The computed byte address appears on the store-address output.
- R6: Opcode 0x2B stores R[rt] at address R[rs] + sign-extended imm16 and makes no register write. A later load from the same address returns the stored word.
- R7: Opcode 0x04 compares R[rs] with R[rt] by subtraction. When they are equal, the next PC is PC+4+(sign-extended imm16 shifted left by 2); otherwise it is PC+4. It writes neither registers nor memory.
- R8: Opcode 0x02 sets the next PC to {PC+4 bits [31:28], target[25:0], 2'b00} and writes neither registers nor memory.
- R9: Register 0 always reads as zero. A write aimed at it has no lasting effect.
- R10: An unknown opcode, or an R-format word with an unknown funct, writes neither registers nor memory and advances the PC by 4.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Program counter of the instruction now executing |
| rf_we_o | output | 1 | This instruction writes a register |
| rf_waddr_o | output | 5 | Index of the register being written |
| rf_wdata_o | output | 32 | Value being written back |
| dm_we_o | output | 1 | This instruction stores a word |
| dm_addr_o | output | 32 | Computed data byte address (ALU result) |
| dm_wdata_o | output | 32 | Value being stored (second register read) |

## Verification
Register contents are not visible on any port. The hardest conditions to reach are that a write to register 0 left it at zero and that an undecodable word left a register untouched. The stimulus therefore follows each such case with a store of the register in question, so its value appears on the store-data output. Backward branches and jumps are reached by placing instructions at non-sequential addresses. The expected-result table is listed in execution order, each row carrying its own PC. A taken branch, a backward branch and a jump land exactly where the table expects.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORIMM = 6'h0D;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;      // 1: write index from rd, 0: from rt
    logic    src_imm;     // 1: second ALU operand is the extended immediate
    logic    zext_imm;    // 1: zero-extend, 0: sign-extend
    logic    mem_to_reg;  // 1: write back loaded word
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] alu_eval(alu_op_e op, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] extend_imm(logic [15:0] imm, logic zext);
    return zext ? {{(XLEN-16){1'b0}}, imm} : {{(XLEN-16){imm[15]}}, imm};
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctl.reg_write  = 1'b1;
        ctl.src_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctl.src_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_ORIMM: begin
        ctl.reg_write = 1'b1;
        ctl.src_imm   = 1'b1;
        ctl.zext_imm  = 1'b1;
        ctl.alu_op    = ALU_OR;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end

  // R6: a store never writes back; R7/R8: redirects never write anything
  always_comb begin
    p_store_no_wb_r6: assert (!(ctl.mem_write && ctl.reg_write));
    p_redirect_quiet_r7: assert (!((ctl.branch || ctl.jump) && (ctl.reg_write || ctl.mem_write)));
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);

  // R7: the subtraction flag means operand equality
  always_comb begin
    if (op == ALU_SUB) p_zero_means_equal_r7: assert (zero == (a == b));
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int AW = RIDX,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(g))) regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R2: a write to a nonzero register lands by the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
  // R9: a write aimed at register 0 leaves it reading zero
  p_r0_stays_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int IMEM_WORDS = 1 << IMEM_AW,
  localparam int DMEM_WORDS = 1 << DMEM_AW
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [RIDX-1:0] rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, j_target;
  logic [XLEN-1:0] instr, imm_ext, rd_a, rd_b, alu_b, alu_y, dm_rdata, wb_data;
  logic [RIDX-1:0] waddr;
  logic            alu_zero, branch_taken;
  ctrl_t           ctl;

  assign instr = imem[pc[IMEM_AW+1:2]];

  sc_ctrl u_ctrl (.op(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign waddr = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile u_rf (
    .clk(clk), .rst(rst), .we(ctl.reg_write), .waddr(waddr), .wdata(wb_data),
    .raddr_a(instr[25:21]), .raddr_b(instr[20:16]), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  assign imm_ext = extend_imm(instr[15:0], ctl.zext_imm);
  assign alu_b   = ctl.src_imm ? imm_ext : rd_b;

  sc_alu u_alu (.op(ctl.alu_op), .a(rd_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign dm_rdata = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data  = ctl.mem_to_reg ? dm_rdata : alu_y;

  assign pc_plus4     = pc + XLEN'(4);
  assign br_target    = pc_plus4 + (imm_ext << 2);
  assign j_target     = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign branch_taken = ctl.branch && alu_zero;

  always_comb begin
    if (ctl.jump)          pc_next = j_target;
    else if (branch_taken) pc_next = br_target;
    else                   pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ctl.mem_write) dmem[alu_y[DMEM_AW+1:2]] <= rd_b;
  end

  assign pc_o       = pc;
  assign rf_we_o    = ctl.reg_write;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctl.mem_write;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rd_b;

  // R1: reset forces the counter to zero
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc == '0));
  // R11: no redirect means a plain step of four bytes
  p_seq_step_r11: assert property (@(posedge clk) disable iff (rst)
    (!branch_taken && !ctl.jump) |=> (pc == $past(pc) + XLEN'(4)));
  // R7: a taken branch lands at the scaled offset past the next word
  p_branch_dest_r7: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> ($signed(pc - $past(pc) - XLEN'(4)) == ($signed($past(imm_ext)) * 4)));
  // R8: a jump keeps the upper nibble and takes the target field
  p_jump_dest_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));
  // R6: one instruction never both stores and writes back
  p_single_effect_r6: assert property (@(posedge clk) disable iff (rst)
    !(dm_we_o && rf_we_o));
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] pc;
    logic [31:0] instr;
    logic        rfwe;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic        dmwe;
    logic [31:0] daddr;
    logic [31:0] dwdata;
  } vec_t;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic vec_t wr(int rq, int pc, logic [31:0] ins, int wa, logic [31:0] wd);
    return '{8'(rq), 32'(pc), ins, 1'b1, 5'(wa), wd, 1'b0, 32'd0, 32'd0};
  endfunction
  function automatic vec_t st(int rq, int pc, logic [31:0] ins, logic [31:0] a, logic [31:0] d);
    return '{8'(rq), 32'(pc), ins, 1'b0, 5'd0, 32'd0, 1'b1, a, d};
  endfunction
  function automatic vec_t nw(int rq, int pc, logic [31:0] ins);
    return '{8'(rq), 32'(pc), ins, 1'b0, 5'd0, 32'd0, 1'b0, 32'd0, 32'd0};
  endfunction

  localparam int NV = 26;
  // rows in execution order; each carries the requirement it exercises
  localparam vec_t VECS [NV] = '{
    wr(4,   0, enc_i(6'h0D, 0, 1, 16'h0010), 1, 32'h0000_0010),          // R4 R1
    wr(4,   4, enc_i(6'h0D, 0, 2, 16'hFFFF), 2, 32'h0000_FFFF),          // R4 zero-extend
    wr(2,   8, enc_r(1, 2, 3, 6'h20), 3, 32'h0001_000F),                 // R2 add
    wr(2,  12, enc_r(1, 2, 4, 6'h22), 4, 32'hFFFF_0011),                 // R2 sub
    wr(2,  16, enc_r(3, 2, 5, 6'h24), 5, 32'h0000_000F),                 // R2 and
    wr(2,  20, enc_r(1, 2, 6, 6'h25), 6, 32'h0000_FFFF),                 // R2 or
    wr(3,  24, enc_r(4, 1, 7, 6'h2A), 7, 32'd1),                         // R3 negative < positive
    wr(3,  28, enc_r(1, 4, 8, 6'h2A), 8, 32'd0),                         // R3 positive vs negative
    wr(3,  32, enc_r(1, 1, 9, 6'h2A), 9, 32'd0),                         // R3 equal
    wr(5,  36, enc_i(6'h23, 1, 10, 16'h0000), 10, 32'hCAFE_F00D),        // R5
    wr(5,  40, enc_i(6'h23, 1, 11, 16'h0004), 11, 32'h8000_0001),        // R5
    wr(4,  44, enc_i(6'h0D, 0, 13, 16'h0018), 13, 32'h0000_0018),        // R4
    wr(5,  48, enc_i(6'h23, 13, 12, 16'hFFF8), 12, 32'hCAFE_F00D),       // R5 negative offset
    st(6,  52, enc_i(6'h2B, 1, 4, 16'h0008), 32'h18, 32'hFFFF_0011),     // R6
    wr(6,  56, enc_i(6'h23, 13, 14, 16'h0000), 14, 32'hFFFF_0011),       // R6 read back
    wr(9,  60, enc_r(1, 2, 0, 6'h20), 0, 32'h0001_000F),                 // R9 aim at r0
    st(9,  64, enc_i(6'h2B, 1, 0, 16'h0000), 32'h10, 32'd0),             // R9 r0 still zero
    nw(10, 68, enc_r(1, 2, 5, 6'h00)),                                   // R10 unknown funct
    nw(10, 72, enc_i(6'h3F, 1, 5, 16'h1234)),                            // R10 unknown opcode
    st(10, 76, enc_i(6'h2B, 1, 5, 16'h000C), 32'h1C, 32'h0000_000F),     // R10 r5 untouched
    nw(7,  80, enc_i(6'h04, 1, 2, 16'h0005)),                            // R7 not taken
    nw(7,  84, enc_i(6'h04, 1, 1, 16'h0003)),                            // R7 taken forward
    nw(7, 100, enc_i(6'h04, 0, 0, 16'hFFFC)),                            // R7 taken backward
    nw(8,  88, {6'h02, 26'd30}),                                         // R8 jump
    wr(8, 120, enc_i(6'h0D, 0, 16, 16'h0055), 16, 32'h0000_0055),        // R8 landed
    st(11, 124, enc_i(6'h2B, 0, 16, 16'h0000), 32'h0, 32'h0000_0055)     // R11
  };

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      u_sc_core.imem[k] = 32'd0;
      u_sc_core.dmem[k] = 32'd0;
    end
    u_sc_core.dmem[4] = 32'hCAFE_F00D;
    u_sc_core.dmem[5] = 32'h8000_0001;
    for (int i = 0; i < NV; i++) u_sc_core.imem[VECS[i].pc[7:2]] = VECS[i].instr;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc_o, 32'd0);
    rst = 1'b0;
    #1;
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      check(rq, $sformatf("row %0d pc", i), pc_o, VECS[i].pc);
      check(rq, $sformatf("row %0d reg write enable", i), 32'(rf_we_o), 32'(VECS[i].rfwe));
      check(rq, $sformatf("row %0d store enable", i), 32'(dm_we_o), 32'(VECS[i].dmwe));
      if (VECS[i].rfwe) begin
        check(rq, $sformatf("row %0d write index", i), 32'(rf_waddr_o), 32'(VECS[i].waddr));
        check(rq, $sformatf("row %0d write value", i), rf_wdata_o, VECS[i].wdata);
      end
      if (VECS[i].dmwe) begin
        check(rq, $sformatf("row %0d store address", i), dm_addr_o, VECS[i].daddr);
        check(rq, $sformatf("row %0d store value", i), dm_wdata_o, VECS[i].dwdata);
      end
      @(posedge clk);
      @(negedge clk);
      #1;
    end

    // R1: reset in mid-run returns to address 0 and reruns the first word
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc after mid-run reset", pc_o, 32'd0);
    rst = 1'b0;
    #1;
    check("R1", "first word write index", 32'(rf_waddr_o), 32'd1);
    check("R1", "first word write value", rf_wdata_o, 32'h0000_0010);
    @(posedge clk);
    @(negedge clk);
    check("R11", "step after reset", pc_o, 32'd4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule